// File: doc/BRIEF.md
# Synchronized Clock Stop Gating Controller

This block stops a group of already generated clocks cleanly when the system asks for low power, and starts them again cleanly when the request goes away. A reference clock `cpu_clk` qualifies an active-low, asynchronous stop request. The request is synchronized first. It is then accepted only when it has been seen low on two consecutive rising edges. After acceptance, each gated output freezes LOW at the next falling edge of its own source clock, so no output ever shows a shortened high phase. Once every output has stopped, the block raises `low_power`, which the clock sources can use to shut down.

Each output also has a static enable bit. An output with a cleared enable is held LOW and does not toggle, whatever the power state is. The enables are meant to be set once after power-on. The block assumes they are quasi-static with respect to the source clocks. When the request returns high, `low_power` drops first. Each gate then reopens at the next falling edge of its source, so the first restored pulse is a full one. The source clocks are inputs and are assumed to be derived from a common reference. Only the stop and restart sequencing is modelled here. There is no streaming data path, so every pin is a plain level-sensitive control or clock pin.

Top module: `clk_stop_ctrl`

## Requirements
- R1: `pd_req_n` is synchronized through two `cpu_clk` flops before use. A low level that is caught by only one rising edge of `cpu_clk` is ignored: `low_power` stays 0 and every enabled output keeps toggling.
- R2: A stop is accepted only after the synchronized request has been low on two consecutive `cpu_clk` rising edges. `low_power` is therefore still 0 four `cpu_clk` edges after the edge that first samples the request low.
- R3: Every high phase seen on `clk_out[i]` lasts exactly one full high phase of `src_clk[i]`. Gates open and close only while the source is low, whether the trigger is stop, restart or an enable change.
- R4: `low_power` asserts only after a stop has been accepted and every gate has been seen closed. While it is 1, all bits of `clk_out` are 0 and none toggles. It asserts within 30 `cpu_clk` cycles of the request falling when all source periods are at most 120 ns.
- R5: When `pd_req_n` returns high, `low_power` returns to 0 within six `cpu_clk` edges. Every enabled output then toggles again, starting with a full pulse.
- R6: An output with `out_en[i]` = 0 is held LOW and does not toggle, while the enabled outputs keep running. `low_power` still asserts during a stop when some outputs are disabled.
- R7: After reset, `low_power` is 0 and no stop is pending. With all enables at 1, every output begins toggling after the first falling edge of its source. During reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_clk | input | 1 | Reference clock that qualifies the stop request and runs the status logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_n | input | 1 | Asynchronous active-low stop request |
| src_clk | input | NUM_OUT | Free-running source clocks, one per output |
| out_en | input | NUM_OUT | Per-output enable, 1 = clock allowed to run |
| clk_out | output | NUM_OUT | Gated clocks |
| low_power | output | 1 | All outputs stopped; clock sources may be switched off |

## Verification
The hardest cases to reach are a request pulse caught by exactly one rising edge of `cpu_clk`, and a stop or restart that falls inside the high phase of a slow source. To reach them, the bench changes `pd_req_n` 5 ns after a chosen `cpu_clk` edge, which places the low level on exactly the edges intended. The source clocks use four unrelated half periods with small phase offsets, so every stop and restart lands in the middle of some output's high phase. A monitor measures the width of every gated high phase against the half period of its source, so any truncated pulse is counted.

// File: rtl/clk_stop_pkg.sv
package clk_stop_pkg;

  // Width of a counter that must reach max_val.
  function automatic int cnt_width(input int max_val);
    return (max_val < 1) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/clk_stop_sync.sv
// Multi-stage flop synchronizer for level signals.
module clk_stop_sync #(
  parameter int WIDTH     = 1,
  parameter int STAGES    = 2,
  parameter bit RESET_VAL = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= {STAGES{{WIDTH{RESET_VAL}}}};
    end else begin
      chain[0] <= d;
      for (int s = 1; s < STAGES; s++) begin
        chain[s] <= chain[s-1];
      end
    end
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/clk_stop_qual.sv
// Accepts a stop only after CONFIRM consecutive low samples of the
// synchronized request; a single high sample cancels it at once.
module clk_stop_qual
  import clk_stop_pkg::*;
#(
  parameter int CONFIRM = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_sync_n,
  output logic accept
);

  localparam int CW = cnt_width(CONFIRM);

  logic [CW-1:0] low_cnt;
  logic          accept_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      accept_q <= 1'b0;
    end else if (req_sync_n) begin
      low_cnt  <= '0;
      accept_q <= 1'b0;
    end else begin
      if (low_cnt != CW'(CONFIRM)) begin
        low_cnt <= low_cnt + 1'b1;
      end
      if (low_cnt == CW'(CONFIRM - 1)) begin
        accept_q <= 1'b1;
      end
    end
  end

  assign accept = accept_q;

endmodule

// File: rtl/clk_gate_cell.sv
// Glitch-free gate: the enable flop updates on the falling edge of the
// source, so the AND gate only changes state while the source is low.
module clk_gate_cell (
  input  logic src_clk,
  input  logic rst_n,
  input  logic run,
  input  logic en,
  output logic clk_out,
  output logic gate_open
);

  logic gate_q;

  always_ff @(negedge src_clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= run & en;
    end
  end

  assign clk_out   = src_clk & gate_q;
  assign gate_open = gate_q;

endmodule

// File: rtl/clk_stop_status.sv
// Raises low_power once a stop is accepted, a settle window has passed
// and every gate is reported closed. SETTLE must cover the slowest
// source period plus the gate-state synchronizer, in cpu_clk cycles.
module clk_stop_status
  import clk_stop_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int SETTLE  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  logic [NUM_OUT-1:0] gate_open_sync,
  output logic               low_power
);

  localparam int SW = cnt_width(SETTLE);

  logic [SW-1:0] settle_cnt;
  logic          lp_q;
  logic          settled;

  assign settled = (settle_cnt == SW'(SETTLE));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      settle_cnt <= '0;
      lp_q       <= 1'b0;
    end else if (!accept) begin
      settle_cnt <= '0;
      lp_q       <= 1'b0;
    end else begin
      if (!settled) begin
        settle_cnt <= settle_cnt + 1'b1;
      end
      lp_q <= settled & ~|gate_open_sync;
    end
  end

  assign low_power = lp_q;

endmodule

// File: rtl/clk_stop_ctrl.sv
module clk_stop_ctrl #(
  parameter int NUM_OUT         = 4,
  parameter int SYNC_STAGES     = 2,
  parameter int CONFIRM_SAMPLES = 2,
  parameter int SETTLE_CYCLES   = 8
) (
  input  logic               cpu_clk,
  input  logic               rst_n,
  input  logic               pd_req_n,
  input  logic [NUM_OUT-1:0] src_clk,
  input  logic [NUM_OUT-1:0] out_en,
  output logic [NUM_OUT-1:0] clk_out,
  output logic               low_power
);

  logic               req_sync_n;
  logic               pd_accept;
  logic               run;
  logic [NUM_OUT-1:0] gate_open;
  logic [NUM_OUT-1:0] gate_open_sync;

  clk_stop_sync #(
    .WIDTH    (1),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b1)
  ) u_req_sync (
    .clk  (cpu_clk),
    .rst_n(rst_n),
    .d    (pd_req_n),
    .q    (req_sync_n)
  );

  clk_stop_qual #(
    .CONFIRM(CONFIRM_SAMPLES)
  ) u_qual (
    .clk       (cpu_clk),
    .rst_n     (rst_n),
    .req_sync_n(req_sync_n),
    .accept    (pd_accept)
  );

  // Gates stay closed until low_power has dropped, so the sources
  // restart before any output is released.
  assign run = ~(pd_accept | low_power);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
    clk_gate_cell u_cell (
      .src_clk  (src_clk[i]),
      .rst_n    (rst_n),
      .run      (run),
      .en       (out_en[i]),
      .clk_out  (clk_out[i]),
      .gate_open(gate_open[i])
    );
  end

  clk_stop_sync #(
    .WIDTH    (NUM_OUT),
    .STAGES   (SYNC_STAGES),
    .RESET_VAL(1'b0)
  ) u_gate_sync (
    .clk  (cpu_clk),
    .rst_n(rst_n),
    .d    (gate_open),
    .q    (gate_open_sync)
  );

  clk_stop_status #(
    .NUM_OUT(NUM_OUT),
    .SETTLE (SETTLE_CYCLES)
  ) u_status (
    .clk           (cpu_clk),
    .rst_n         (rst_n),
    .accept        (pd_accept),
    .gate_open_sync(gate_open_sync),
    .low_power     (low_power)
  );

endmodule

// File: rtl/clk_stop_ctrl_chk.sv
module clk_stop_ctrl_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               cpu_clk,
  input logic               rst_n,
  input logic               req_sync_n,
  input logic               pd_accept,
  input logic               low_power,
  input logic [NUM_OUT-1:0] clk_out
);

  AST_ACCEPT_TWO_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    $rose(pd_accept) |-> (!$past(req_sync_n, 1) && !$past(req_sync_n, 2))); // R2

  AST_LP_AFTER_ACCEPT: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    low_power |-> $past(pd_accept)); // R4

  AST_LP_OUTPUTS_LOW: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    low_power |-> (clk_out == '0)); // R4

  AST_WAKE_CANCELS: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    req_sync_n |=> !pd_accept); // R5

  AST_LP_RELEASE: assert property (@(posedge cpu_clk) disable iff (!rst_n)
    !pd_accept |=> !low_power); // R5

endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .cpu_clk   (cpu_clk),
  .rst_n     (rst_n),
  .req_sync_n(req_sync_n),
  .pd_accept (pd_accept),
  .low_power (low_power),
  .clk_out   (clk_out)
);

// File: tb/tb_clk_stop_ctrl.sv
`timescale 1ns/1ps
module tb_clk_stop_ctrl;

  localparam int NUM_OUT = 4;
  localparam int HALF [NUM_OUT] = '{20, 30, 40, 60};

  logic               cpu_clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               pd_req_n = 1'b1;
  logic [NUM_OUT-1:0] src_clk;
  logic [NUM_OUT-1:0] out_en = '1;
  logic [NUM_OUT-1:0] clk_out;
  logic               low_power;

  int checks = 0;
  int errors = 0;
  int rises [NUM_OUT];
  int runts [NUM_OUT];
  time t_rise [NUM_OUT];
  logic [NUM_OUT-1:0] seen_rise = '0;
  logic [NUM_OUT-1:0] prev_out = '0;

  always #10 cpu_clk = ~cpu_clk;  // 50 MHz

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_src
    logic s = 1'b0;
    initial begin
      #(3 + 2 * i);
      forever #(HALF[i]) s = ~s;
    end
    assign src_clk[i] = s;
  end

  clk_stop_ctrl #(.NUM_OUT(NUM_OUT)) dut (
    .cpu_clk  (cpu_clk),
    .rst_n    (rst_n),
    .pd_req_n (pd_req_n),
    .src_clk  (src_clk),
    .out_en   (out_en),
    .clk_out  (clk_out),
    .low_power(low_power)
  );

  // Pulse monitor: counts rising edges and high phases shorter or longer
  // than the source high phase (R3).
  initial begin
    for (int i = 0; i < NUM_OUT; i++) begin
      rises[i] = 0;
      runts[i] = 0;
      t_rise[i] = 0;
    end
  end

  always @(clk_out) begin
    for (int i = 0; i < NUM_OUT; i++) begin
      if (clk_out[i] === 1'b1 && prev_out[i] !== 1'b1) begin
        rises[i]++;
        t_rise[i] = $time;
        seen_rise[i] = 1'b1;
      end else if (clk_out[i] === 1'b0 && prev_out[i] === 1'b1 && seen_rise[i]) begin
        if (($time - t_rise[i]) != time'(HALF[i])) runts[i]++;
      end
    end
    prev_out = clk_out;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int k = 0; k < n; k++) @(negedge cpu_clk);
  endtask

  task automatic check_no_runts(input string req);
    for (int i = 0; i < NUM_OUT; i++)
      check(runts[i] == 0, req, $sformatf("truncated pulses on output %0d", i), runts[i], 0);
  endtask

  task automatic t_reset;
    wait_cycles(3);
    check(low_power == 1'b0, "R7", "low_power in reset", int'(low_power), 0);
    check(clk_out == '0, "R7", "outputs in reset", int'(clk_out), 0);
    @(posedge cpu_clk); #5 rst_n = 1'b1;
    wait_cycles(20);
    check(low_power == 1'b0, "R7", "low_power after reset", int'(low_power), 0);
    for (int i = 0; i < NUM_OUT; i++)
      check(rises[i] > 0, "R7", $sformatf("output %0d toggling after reset", i), rises[i], 1);
  endtask

  task automatic t_short_pulse;
    int snap [NUM_OUT];
    bit lp_seen = 0;
    for (int i = 0; i < NUM_OUT; i++) snap[i] = rises[i];
    @(posedge cpu_clk); #5 pd_req_n = 1'b0;
    @(posedge cpu_clk); #5 pd_req_n = 1'b1;   // low across one edge only
    for (int k = 0; k < 30; k++) begin
      @(negedge cpu_clk);
      if (low_power) lp_seen = 1;
    end
    check(!lp_seen, "R1", "low_power after one-sample pulse", int'(lp_seen), 0);
    for (int i = 0; i < NUM_OUT; i++)
      check(rises[i] > snap[i] + 2, "R1", $sformatf("output %0d kept running", i),
            rises[i] - snap[i], 3);
  endtask

  task automatic t_enter;
    int snap [NUM_OUT];
    bit moved = 0;
    @(posedge cpu_clk); #5 pd_req_n = 1'b0;
    wait_cycles(4);
    check(low_power == 1'b0, "R2", "low_power before confirmation", int'(low_power), 0);
    wait_cycles(26);
    check(low_power == 1'b1, "R4", "low_power after stop", int'(low_power), 1);
    for (int i = 0; i < NUM_OUT; i++) snap[i] = rises[i];
    for (int k = 0; k < 20; k++) begin
      @(negedge cpu_clk);
      if (clk_out != '0) moved = 1;
    end
    check(!moved, "R4", "outputs low while stopped", int'(moved), 0);
    for (int i = 0; i < NUM_OUT; i++)
      check(rises[i] == snap[i], "R4", $sformatf("output %0d frozen", i),
            rises[i] - snap[i], 0);
    check(low_power == 1'b1, "R4", "low_power held", int'(low_power), 1);
    check_no_runts("R3");
  endtask

  task automatic t_exit;
    int snap [NUM_OUT];
    for (int i = 0; i < NUM_OUT; i++) snap[i] = rises[i];
    @(posedge cpu_clk); #5 pd_req_n = 1'b1;
    wait_cycles(6);
    check(low_power == 1'b0, "R5", "low_power after wake", int'(low_power), 0);
    wait_cycles(30);
    for (int i = 0; i < NUM_OUT; i++)
      check(rises[i] > snap[i], "R5", $sformatf("output %0d restarted", i),
            rises[i] - snap[i], 1);
    check_no_runts("R5");
  endtask

  task automatic t_disable;
    int snap [NUM_OUT];
    bit dis_moved = 0;
    @(posedge cpu_clk); #5 out_en = 4'b0101;
    wait_cycles(10);
    for (int i = 0; i < NUM_OUT; i++) snap[i] = rises[i];
    for (int k = 0; k < 20; k++) begin
      @(negedge cpu_clk);
      if (clk_out[1] || clk_out[3]) dis_moved = 1;
    end
    check(!dis_moved, "R6", "disabled outputs low", int'(dis_moved), 0);
    check(rises[1] == snap[1] && rises[3] == snap[3], "R6", "disabled outputs frozen",
          rises[1] + rises[3] - snap[1] - snap[3], 0);
    check(rises[0] > snap[0] && rises[2] > snap[2], "R6", "enabled outputs running",
          rises[0] + rises[2] - snap[0] - snap[2], 2);
    @(posedge cpu_clk); #5 pd_req_n = 1'b0;
    wait_cycles(30);
    check(low_power == 1'b1, "R6", "stop with partial enables", int'(low_power), 1);
    check(clk_out == '0, "R6", "outputs during partial stop", int'(clk_out), 0);
    @(posedge cpu_clk); #5 pd_req_n = 1'b1;
    wait_cycles(10);
    @(posedge cpu_clk); #5 out_en = '1;
    wait_cycles(10);
    for (int i = 0; i < NUM_OUT; i++) snap[i] = rises[i];
    wait_cycles(20);
    for (int i = 0; i < NUM_OUT; i++)
      check(rises[i] > snap[i], "R6", $sformatf("output %0d re-enabled", i),
            rises[i] - snap[i], 1);
    check_no_runts("R3");
  endtask

  initial begin
    #(150000 * 20);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_short_pulse();
    t_enter();
    t_exit();
    t_disable();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule